// File: doc/BRIEF.md
# I2C Target Byte Engine

This block is the target (slave) side of a two-wire serial bus. It samples the clock and data lines in the system clock domain through two-flop synchronisers and detects START and STOP on the synchronised lines. On each START it checks the address byte against a programmable 7-bit address. It then either collects bytes from the controller into a receive FIFO or sends bytes from a transmit FIFO. The lines are open drain. The block never drives a line high: it only asserts an enable that pulls the line low.

Between bus phases the engine holds the clock line low for a few system cycles. This gives it time to set up the next phase: load the next transmit byte, push the last received byte, or arm the acknowledge. A host fills the transmit FIFO with a valid/ready push and drains the receive FIFO with a valid/pop interface. Both FIFOs are ring buffers with a power-of-two number of slots, and one slot is always left unused.

State names:
- `ST_IDLE`: waiting for START.
- `ST_START_WAIT`: START seen, waiting for the clock to fall.
- `ST_ADDR`: address byte.
- `ST_ADDR_ACK`: address acknowledge.
- `ST_TX_BYTE` and `ST_TX_ACK`: send a byte, then sample the controller's acknowledge.
- `ST_RX_BYTE` and `ST_RX_ACK`: take a byte, then drive an acknowledge.

Transitions:
- START from any state goes to `ST_START_WAIT`.
- STOP from any state goes to `ST_IDLE`.
- `ST_START_WAIT` goes to `ST_ADDR` on a clock fall.
- `ST_ADDR` goes to `ST_ADDR_ACK` on a hit and to `ST_IDLE` on a miss.
- `ST_ADDR_ACK` goes to `ST_TX_BYTE` for a read with data ready, to `ST_IDLE` for a read with no data, and to `ST_RX_BYTE` for a write.
- `ST_TX_BYTE` goes to `ST_TX_ACK`.
- `ST_TX_ACK` goes to `ST_TX_BYTE` on ACK with data ready, and to `ST_IDLE` on NACK or with no data.
- `ST_RX_BYTE` goes to `ST_RX_ACK`.
- `ST_RX_ACK` goes to `ST_RX_BYTE`.

Top module: `i2c_tgt_engine`

## Requirements
- R1: After reset, neither line is pulled low, `rx_valid` is 0 and `tx_ready` is 1.
- R2: An address byte whose bits 7..1 equal `own_addr` is acknowledged: the target pulls SDA low during the ninth clock.
- R3: The address byte 0x00 (general call, write) is acknowledged, and the data bytes that follow are received.
- R4: Any other address byte is not acknowledged. The engine returns to idle, and the data bytes that follow are neither acknowledged nor stored.
- R5: With direction bit 0 (controller writes), each byte is shifted in MSB first on rising SCL edges, pushed into the receive FIFO, and acknowledged with a 0.
- R6: With direction bit 1 (controller reads), bytes are taken from the transmit FIFO in push order and driven MSB first. SDA changes only while SCL is low. After an ACK (0), the next byte follows.
- R7: A NACK (1) after a transmitted byte ends the transfer: SDA is released, and unsent bytes stay in the transmit FIFO for the next read.
- R8: If the transmit FIFO is empty when a byte is due, the engine releases SDA and goes idle, so the controller reads 0xFF.
- R9: SCL is held low after the clock fall that follows START, and after every byte or acknowledge phase that leads to another active phase. A write of n bytes therefore shows 3+2n stretch pulses.
- R10: A STOP while waiting for SCL to fall after START returns the engine to idle. An address byte clocked afterwards without a new START is ignored.
- R11: A repeated START at any point restarts the engine at the address phase.
- R12: The transmit FIFO holds TX_DEPTH-1 bytes. When it is full, `tx_ready` is 0 and a push is discarded.
- R13: `rx_valid` shows that a received byte is waiting, `rx_data` presents the oldest one, and `rx_pop` removes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset; also empties both FIFOs |
| own_addr | input | 7 | Programmed target address |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level |
| scl_oe | output | 1 | Pull SCL low (clock stretch) |
| sda_oe | output | 1 | Pull SDA low |
| tx_data | input | 8 | Byte to queue for transmission |
| tx_push | input | 1 | Push `tx_data` into the transmit FIFO |
| tx_ready | output | 1 | Transmit FIFO has room |
| rx_data | output | 8 | Oldest received byte |
| rx_valid | output | 1 | Receive FIFO not empty |
| rx_pop | input | 1 | Remove the oldest received byte |

## Verification
The bench models the bus as a wired-AND. A controller model waits for SCL to actually rise, so it always respects stretching. Directed cases cover the following:
- General call: a design that compared only bits 7..1 would reject 0x00.
- Foreign address: a design that failed to go idle would store the data that follows.
- Reading from an empty FIFO: a design that sent stale data would return something other than 0xFF.
- NACK that leaves data queued: a design that popped ahead would lose the following byte.
- STOP straight after START: a design that entered the address phase would acknowledge an address sent without a START.
- Repeated START in the middle of a write.

A full transmit FIFO is also pushed, where an overrun would send the refused byte. Randomly addressed write and read transfers check data order and MSB-first shifting against a queue model.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_START_WAIT,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_TX_BYTE,
        ST_TX_ACK,
        ST_RX_BYTE,
        ST_RX_ACK
    } tgt_state_e;

endpackage

// File: rtl/i2c_tgt_sync.sv
module i2c_tgt_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    // Idle bus level is high, so the flops reset to ones.
    logic [W-1:0] stg [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg[0] <= '1;
                else        stg[0] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg[g] <= '1;
                else        stg[g] <= stg[g-1];
            end
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/i2c_tgt_fifo.sv
module i2c_tgt_fifo #(
    parameter int DW    = 8,
    parameter int DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    output logic          full,
    input  logic          rd_en,
    output logic [DW-1:0] rd_data,
    output logic          empty
);
    localparam int AW = $clog2(DEPTH);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] head, tail;
    logic [AW-1:0] head_nxt, tail_nxt;

    // Index advances before use; one slot is never filled.
    assign head_nxt = head + AW'(1);
    assign tail_nxt = tail + AW'(1);
    assign full     = (head_nxt == tail);
    assign empty    = (head == tail);
    assign rd_data  = mem[tail_nxt];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            head <= '0;
            tail <= '0;
        end else begin
            if (wr_en && !full)  head <= head_nxt;
            if (rd_en && !empty) tail <= tail_nxt;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en && !full) mem[head_nxt] <= wr_data;
    end

    // R12: a push into a full buffer is refused, so it stays full.
    a_r12_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !rd_en) |=> full);

    // R13: an empty buffer stays empty unless something is pushed.
    a_r13_empty_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && !wr_en) |=> empty);

endmodule

// File: rtl/i2c_tgt_engine.sv
module i2c_tgt_engine
    import i2c_tgt_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int TX_DEPTH  = 4,
    parameter int RX_DEPTH  = 16,
    parameter int STRETCH   = 2,
    parameter int SYNC_FF   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-2:0] own_addr,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              scl_oe,
    output logic              sda_oe,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_push,
    output logic              tx_ready,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid,
    input  logic              rx_pop
);
    localparam int BYTE_EDGES = 2 * DATA_W;
    localparam int ACK_EDGES  = 2;
    localparam int CNT_W      = $clog2(BYTE_EDGES + 1);
    localparam int HOLD_W     = $clog2(STRETCH + 1);

    // ---------------- line sampling ----------------
    logic [1:0] line_s;
    logic       scl_s, sda_s, scl_d, sda_d;

    i2c_tgt_sync #(.W(2), .STAGES(SYNC_FF)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({scl_in, sda_in}),
        .q     (line_s)
    );

    assign scl_s = line_s[1];
    assign sda_s = line_s[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_s;
            sda_d <= sda_s;
        end
    end

    logic scl_rise, scl_fall, start_det, stop_det;
    assign scl_rise  =  scl_s & ~scl_d;
    assign scl_fall  = ~scl_s &  scl_d;
    assign start_det =  scl_s &  scl_d &  sda_d & ~sda_s;
    assign stop_det  =  scl_s &  scl_d & ~sda_d &  sda_s;

    // ---------------- FIFOs ----------------
    logic              tx_full, tx_empty, tx_pop_int;
    logic [DATA_W-1:0] tx_head_byte;
    logic              rx_full, rx_empty, rx_push_int;
    logic [DATA_W-1:0] shreg;

    i2c_tgt_fifo #(.DW(DATA_W), .DEPTH(TX_DEPTH)) u_tx_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (tx_push),
        .wr_data (tx_data),
        .full    (tx_full),
        .rd_en   (tx_pop_int),
        .rd_data (tx_head_byte),
        .empty   (tx_empty)
    );

    // A byte arriving while the receive buffer is full is discarded.
    i2c_tgt_fifo #(.DW(DATA_W), .DEPTH(RX_DEPTH)) u_rx_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (rx_push_int),
        .wr_data (shreg),
        .full    (rx_full),
        .rd_en   (rx_pop),
        .rd_data (rx_data),
        .empty   (rx_empty)
    );

    assign tx_ready = !tx_full;
    assign rx_valid = !rx_empty;

    // ---------------- state machine ----------------
    tgt_state_e        state, nxt;
    logic [CNT_W-1:0]  edge_cnt, cnt_inc, phase_len;
    logic [HOLD_W-1:0] hold_cnt;
    logic              dir_rd, ack_bit;
    logic              active, phase_end, addr_hit, enter_hold;

    always_comb begin
        active     = !(state inside {ST_IDLE, ST_START_WAIT});
        phase_len  = (state inside {ST_ADDR, ST_TX_BYTE, ST_RX_BYTE})
                     ? CNT_W'(BYTE_EDGES) : CNT_W'(ACK_EDGES);
        cnt_inc    = edge_cnt + CNT_W'(1);
        phase_end  = active && scl_fall && (cnt_inc == phase_len);
        addr_hit   = (shreg == '0) || (shreg[DATA_W-1:1] == own_addr);

        nxt = state;
        unique case (state)
            ST_IDLE:       nxt = ST_IDLE;
            ST_START_WAIT: if (scl_fall) nxt = ST_ADDR;
            ST_ADDR:       if (phase_end) nxt = addr_hit ? ST_ADDR_ACK : ST_IDLE;
            ST_ADDR_ACK:   if (phase_end) nxt = !dir_rd ? ST_RX_BYTE :
                                                (tx_empty ? ST_IDLE : ST_TX_BYTE);
            ST_TX_BYTE:    if (phase_end) nxt = ST_TX_ACK;
            ST_TX_ACK:     if (phase_end) nxt = (!ack_bit && !tx_empty) ? ST_TX_BYTE : ST_IDLE;
            ST_RX_BYTE:    if (phase_end) nxt = ST_RX_ACK;
            ST_RX_ACK:     if (phase_end) nxt = ST_RX_BYTE;
        endcase
        if (stop_det)  nxt = ST_IDLE;
        if (start_det) nxt = ST_START_WAIT;

        enter_hold  = (nxt != state) && !(nxt inside {ST_IDLE, ST_START_WAIT});
        tx_pop_int  = (nxt == ST_TX_BYTE) && (state != ST_TX_BYTE);
        rx_push_int = (state == ST_RX_BYTE) && phase_end && !start_det && !stop_det;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            edge_cnt <= '0;
            hold_cnt <= '0;
            shreg    <= '0;
            dir_rd   <= 1'b0;
            ack_bit  <= 1'b1;
        end else begin
            state <= nxt;

            if (nxt != state)                 edge_cnt <= '0;
            else if (scl_rise || scl_fall)    edge_cnt <= cnt_inc;

            if (nxt inside {ST_IDLE, ST_START_WAIT}) hold_cnt <= '0;
            else if (enter_hold)                     hold_cnt <= HOLD_W'(STRETCH);
            else if (hold_cnt != '0)                 hold_cnt <= hold_cnt - HOLD_W'(1);

            if (tx_pop_int)
                shreg <= tx_head_byte;
            else if (scl_rise && (state inside {ST_ADDR, ST_RX_BYTE}))
                shreg <= {shreg[DATA_W-2:0], sda_s};
            else if (scl_fall && state == ST_TX_BYTE)
                shreg <= {shreg[DATA_W-2:0], 1'b1};

            if (state == ST_ADDR && phase_end) dir_rd  <= shreg[0];
            if (state == ST_TX_ACK && scl_rise) ack_bit <= sda_s;
        end
    end

    // ---------------- outputs ----------------
    always_comb begin
        scl_oe = (hold_cnt != '0);
        unique case (state)
            ST_ADDR_ACK, ST_RX_ACK: sda_oe = 1'b1;
            ST_TX_BYTE:             sda_oe = ~shreg[DATA_W-1];
            default:                sda_oe = 1'b0;
        endcase
    end

    // ---------------- assertions ----------------
    // R9: stretching never outlives an active transfer.
    a_r9_idle_no_stretch: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !scl_oe);

    // R10: after a STOP both lines are released.
    a_r10_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (!sda_oe && !scl_oe));

    // R11: a START from any state restarts at the address phase.
    a_r11_restart: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (state == ST_START_WAIT));

    // R4: an address miss ends in idle.
    a_r4_miss_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ADDR && phase_end && !addr_hit && !start_det) |=> (state == ST_IDLE));

    // R6: SDA is newly pulled low only while SCL is low.
    a_r6_sda_change_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_s);

endmodule

// File: tb/i2c_tgt_engine_tb.sv
module i2c_tgt_engine_tb;

    localparam int Q = 6;
    localparam logic [6:0] OWN = 7'h2A;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       m_scl = 1'b1, m_sda = 1'b1;
    logic       scl_oe, sda_oe;
    logic [7:0] tx_data = '0;
    logic       tx_push = 1'b0;
    logic       tx_ready;
    logic [7:0] rx_data;
    logic       rx_valid;
    logic       rx_pop = 1'b0;
    logic       scl_bus, sda_bus;

    assign scl_bus = m_scl & ~scl_oe;
    assign sda_bus = m_sda & ~sda_oe;

    always #10 clk = ~clk;

    i2c_tgt_engine u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .own_addr (OWN),
        .scl_in   (scl_bus),
        .sda_in   (sda_bus),
        .scl_oe   (scl_oe),
        .sda_oe   (sda_oe),
        .tx_data  (tx_data),
        .tx_push  (tx_push),
        .tx_ready (tx_ready),
        .rx_data  (rx_data),
        .rx_valid (rx_valid),
        .rx_pop   (rx_pop)
    );

    int checks = 0;
    int errors = 0;
    int str_cnt = 0;
    logic scl_oe_q = 1'b0;

    always @(posedge clk) begin
        scl_oe_q <= scl_oe;
        if (scl_oe && !scl_oe_q) str_cnt <= str_cnt + 1;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic raise_scl();
        m_scl = 1'b1;
        @(negedge clk);
        while (scl_bus !== 1'b1) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; wq();
        raise_scl();  wq();
        m_sda = 1'b0; wq();
        m_scl = 1'b0; wq();
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; wq();
        raise_scl();  wq();
        m_sda = 1'b1; wq();
    endtask

    task automatic bit_xfer(input logic b, output logic r);
        m_sda = b; wq();
        raise_scl(); wq();
        r = sda_bus; wq();
        m_scl = 1'b0; wq();
    endtask

    task automatic byte_xfer(input logic [7:0] d, output logic [7:0] r);
        logic x;
        for (int i = 7; i >= 0; i--) begin
            bit_xfer(d[i], x);
            r[i] = x;
        end
    endtask

    task automatic push_tx(input logic [7:0] b);
        tx_data = b; tx_push = 1'b1;
        @(negedge clk);
        tx_push = 1'b0;
        @(negedge clk);
    endtask

    task automatic pop_rx(input string tag, input logic [7:0] exp);
        chk({tag, " rx_valid"}, rx_valid, 1);
        chk({tag, " rx_data"}, rx_data, exp);
        rx_pop = 1'b1;
        @(negedge clk);
        rx_pop = 1'b0;
        @(negedge clk);
    endtask

    logic [7:0] wbuf [8];
    logic [7:0] rbuf [8];

    // Write transfer; ack bits are returned (0 = acknowledged).
    task automatic do_write(input logic [7:0] abyte, input int n,
                            output logic aack, output logic [7:0] dack);
        logic [7:0] r;
        logic a;
        bus_start();
        byte_xfer(abyte, r);
        bit_xfer(1'b1, aack);
        dack = '0;
        for (int i = 0; i < n; i++) begin
            byte_xfer(wbuf[i], r);
            bit_xfer(1'b1, a);
            dack[i] = a;
        end
        bus_stop();
    endtask

    task automatic do_read(input int n, output logic aack);
        logic [7:0] r;
        logic a;
        bus_start();
        byte_xfer({OWN, 1'b1}, r);
        bit_xfer(1'b1, aack);
        for (int i = 0; i < n; i++) begin
            byte_xfer(8'hFF, r);
            rbuf[i] = r;
            bit_xfer((i == n - 1), a);
        end
        bus_stop();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic       aack, x;
        logic [7:0] dack, r;
        int         s0, n;
        logic [6:0] ra;
        void'($urandom(32'd1234));

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R1 reset state
        chk("R1 scl_oe", scl_oe, 0);
        chk("R1 sda_oe", sda_oe, 0);
        chk("R1 rx_valid", rx_valid, 0);
        chk("R1 tx_ready", tx_ready, 1);

        // R2 R5 R9 own-address write of two bytes
        wbuf[0] = 8'hA5; wbuf[1] = 8'h3C;
        s0 = str_cnt;
        do_write({OWN, 1'b0}, 2, aack, dack);
        chk("R2 address ack", aack, 0);
        chk("R5 data acks", dack[1:0], 0);
        chk("R9 stretch pulses", str_cnt - s0, 7);
        pop_rx("R5 R13 first", 8'hA5);
        pop_rx("R5 R13 second", 8'h3C);
        chk("R13 empty after pops", rx_valid, 0);

        // R3 general call
        wbuf[0] = 8'h5A;
        do_write(8'h00, 1, aack, dack);
        chk("R3 general call ack", aack, 0);
        chk("R3 data ack", dack[0], 0);
        pop_rx("R3 data", 8'h5A);

        // R4 foreign address
        wbuf[0] = 8'h77;
        do_write({OWN ^ 7'h01, 1'b0}, 1, aack, dack);
        chk("R4 no address ack", aack, 1);
        chk("R4 no data ack", dack[0], 1);
        chk("R4 nothing stored", rx_valid, 0);

        // R12 transmit FIFO capacity
        chk("R12 ready empty", tx_ready, 1);
        push_tx(8'hC3);
        push_tx(8'h96);
        push_tx(8'h0F);
        chk("R12 ready when full", tx_ready, 0);
        push_tx(8'hEE);

        // R6 read two bytes, ACK then NACK
        do_read(2, aack);
        chk("R2 read address ack", aack, 0);
        chk("R6 first byte", rbuf[0], 8'hC3);
        chk("R6 second byte", rbuf[1], 8'h96);
        chk("R7 sda released after nack", sda_oe, 0);

        // R7 R12 remaining byte kept, refused byte absent
        do_read(1, aack);
        chk("R7 kept byte", rbuf[0], 8'h0F);

        // R8 empty transmit FIFO
        do_read(1, aack);
        chk("R8 address ack", aack, 0);
        chk("R8 idle bus byte", rbuf[0], 8'hFF);

        // R10 START then STOP before SCL falls; then address without START
        m_sda = 1'b0; wq();
        m_sda = 1'b1; wq();
        m_scl = 1'b0; wq();
        s0 = str_cnt;
        byte_xfer({OWN, 1'b0}, r);
        bit_xfer(1'b1, x);
        chk("R10 no ack without start", x, 1);
        chk("R10 no stretch", str_cnt - s0, 0);
        bus_stop();

        // R11 repeated START inside a write
        push_tx(8'h81);
        bus_start();
        byte_xfer({OWN, 1'b0}, r);
        bit_xfer(1'b1, x);
        byte_xfer(8'h11, r);
        bit_xfer(1'b1, x);
        chk("R11 pre-restart data ack", x, 0);
        bus_start();
        byte_xfer({OWN, 1'b1}, r);
        bit_xfer(1'b1, x);
        chk("R11 restart address ack", x, 0);
        byte_xfer(8'hFF, r);
        bit_xfer(1'b1, x);
        chk("R11 read after restart", r, 8'h81);
        bus_stop();
        pop_rx("R11 byte before restart", 8'h11);

        // Random write transfers (R4 R5)
        for (int it = 0; it < 10; it++) begin
            n = 1 + ($urandom % 5);
            for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
            ra = ($urandom % 2) ? OWN : 7'($urandom);
            if (ra == 7'h00) ra = 7'h01;
            do_write({ra, 1'b0}, n, aack, dack);
            if (ra == OWN) begin
                chk("R5 random address ack", aack, 0);
                for (int i = 0; i < n; i++) pop_rx("R5 random byte", wbuf[i]);
            end else begin
                chk("R4 random miss", aack, 1);
                chk("R4 random nothing stored", rx_valid, 0);
            end
        end

        // Random read transfers (R6)
        for (int it = 0; it < 8; it++) begin
            n = 1 + ($urandom % 3);
            for (int i = 0; i < n; i++) begin
                wbuf[i] = 8'($urandom);
                push_tx(wbuf[i]);
            end
            do_read(n, aack);
            chk("R6 random address ack", aack, 0);
            for (int i = 0; i < n; i++) chk("R6 random byte", rbuf[i], wbuf[i]);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule